// File: doc/BRIEF.md
# Two-Level Lookahead Adder (16 bit)

This block adds two 16-bit operands and a carry-in, and returns the 16-bit sum and the carry-out without any carry that ripples from one bit to the next. The datapath has four 4-bit groups. Each group reduces its bits to a single generate/propagate pair. A second-level unit combines these pairs to produce the carry into every group at the same time.

Each bit forms a generate term (both operands set) and a propagate term (at least one operand set). Inside a group, every internal carry is written out in full sum-of-products form. Between groups, adjacent spans are joined with an associative combine rule. The rule takes the high span's generate OR'd with the high propagate AND the low generate, and AND's the two propagates. The low half (bits 0..7) and the high half (bits 8..15) are formed first, and the whole word is formed from those two. The overall generate/propagate pair is brought out on ports, so a wider adder can treat this block as one group of a higher-level tree.

The block is purely combinational. It has no clock or reset.

Top module: `cla16_adder`

## Requirements
- R1: `{cout, sum}` equals the 17-bit value `a + b + cin` for every input combination.
- R2: Bit i propagates when `a[i] | b[i]` is 1 and generates when `a[i] & b[i]` is 1. `grp_p` is 1 exactly when every bit propagates, for example `a=16'hF0F0, b=16'h0F0F`.
- R3: A carry that starts inside a 4-bit group reaches the higher bits of that group. For example, `16'h0007 + 16'h0001` gives `16'h0008`.
- R4: The carry into bit 4 comes from group 0's pair and `cin`. The carry into bit 8 comes from the bits 0..7 pair and `cin`. For example, `16'h00FF + 16'h0001` gives `16'h0100`.
- R5: The carry into bit 12 comes from group 2's pair and the carry into bit 8. For example, `16'h0FFF + 16'h0001` gives `16'h1000`.
- R6: When every bit propagates and none generates, `cin` alone sets `cout` and clears every sum bit. For example, `16'hFFFF + 16'h0000 + 1` gives sum 0 and `cout` 1.
- R7: `grp_g` is 1 exactly when `a + b`, with `cin` forced to 0, carries out of bit 15.
- R8: `cout` equals `grp_g | (grp_p & cin)`.
- R9: `grp_g` and `grp_p` do not depend on `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_g | output | 1 | Generate of the whole 16-bit span |
| grp_p | output | 1 | Propagate of the whole 16-bit span |

## Verification
All outputs are combinational, so every result is due in the same cycle its operands are applied, with no register delay. The bench drives a new operand set on a rising clock edge and samples at the next falling edge. This gives the logic half a period to settle and keeps sampling away from the edge where the drive happens.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Join two adjacent spans: hi is the more significant one.
  function automatic gp_t gp_join(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Carry out of a span, given the carry entering it.
  function automatic logic gp_carry(gp_t s, logic c_in);
    return s.g | (s.p & c_in);
  endfunction
endpackage

// File: rtl/cla_bitgp.sv
module cla_bitgp #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] | b[i];
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output gp_t           grp
);
  logic [GW-1:0] gen, prop;
  logic [GW:0]   cy;

  cla_bitgp #(.N(GW)) u_bits (.a(a), .b(b), .gen(gen), .prop(prop));

  // Flat sum-of-products carry into position k: no term depends on another carry.
  function automatic logic sop_carry(logic [GW-1:0] g, logic [GW-1:0] p, logic c0, int k);
    logic acc, t;
    acc = 1'b0;
    for (int j = 0; j < k; j++) begin
      t = g[j];
      for (int m = j + 1; m < k; m++) t = t & p[m];
      acc = acc | t;
    end
    t = c0;
    for (int m = 0; m < k; m++) t = t & p[m];
    return acc | t;
  endfunction

  always_comb begin
    for (int k = 0; k <= GW; k++) cy[k] = sop_carry(gen, prop, cin, k);
  end

  assign sum   = a ^ b ^ cy[GW-1:0];
  assign grp.g = sop_carry(gen, prop, 1'b0, GW);
  assign grp.p = &prop;

  // R3: the flat carries must agree with the one-step recurrence.
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      for (int k = 0; k < GW; k++) begin
        a_r3_recurrence: assert (cy[k+1] == (gen[k] | (prop[k] & cy[k])));
      end
      a_r8_group_out: assert (cy[GW] == (grp.g | (grp.p & cin)));
    end
  end
endmodule

// File: rtl/cla_level2.sv
module cla_level2
  import cla_pkg::*;
(
  input  gp_t [3:0]  grp,
  input  logic       cin,
  output logic [3:0] gcin,
  output logic       cout,
  output gp_t        top
);
  gp_t lo_half, hi_half;

  assign lo_half = gp_join(grp[1], grp[0]);
  assign hi_half = gp_join(grp[3], grp[2]);
  assign top     = gp_join(hi_half, lo_half);

  assign gcin[0] = cin;
  assign gcin[1] = gp_carry(grp[0], cin);
  assign gcin[2] = gp_carry(lo_half, cin);
  assign gcin[3] = gp_carry(grp[2], gcin[2]);
  assign cout    = gp_carry(top, cin);

  always_comb begin
    if (!$isunknown({grp, cin})) begin
      // R5: carry into group 3 equals its fully expanded form.
      a_r5_c12_flat: assert (gcin[3] == (grp[2].g | (grp[2].p & grp[1].g)
                                          | (grp[2].p & grp[1].p & grp[0].g)
                                          | (grp[2].p & grp[1].p & grp[0].p & cin)));
      // R4: carry into group 2 agrees with a group-by-group step.
      a_r4_c8_step: assert (gcin[2] == (grp[1].g | (grp[1].p & gcin[1])));
      // R8: top carry agrees with the last group's own step.
      a_r8_cout_step: assert (cout == (grp[3].g | (grp[3].p & gcin[3])));
    end
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [4*GW-1:0] a,
  input  logic [4*GW-1:0] b,
  input  logic            cin,
  output logic [4*GW-1:0] sum,
  output logic            cout,
  output logic            grp_g,
  output logic            grp_p
);
  localparam int NG = 4;
  localparam int W  = NG * GW;

  gp_t [NG-1:0]   grp;
  logic [NG-1:0]  gcin;
  gp_t            top;

  for (genvar i = 0; i < NG; i++) begin : g_grp
    cla_group #(.GW(GW)) u_grp (
      .a   (a[i*GW +: GW]),
      .b   (b[i*GW +: GW]),
      .cin (gcin[i]),
      .sum (sum[i*GW +: GW]),
      .grp (grp[i])
    );
  end

  cla_level2 u_l2 (.grp(grp), .cin(cin), .gcin(gcin), .cout(cout), .top(top));

  assign grp_g = top.g;
  assign grp_p = top.p;

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      a_r1_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
      a_r7_gen_carries: assert (!grp_g || cout);
      a_r9_kill_blocks: assert (grp_g || grp_p || !cout);
    end
  end
endmodule

// File: tb/cla16_adder_test.sv
`timescale 1ns/1ps
module cla16_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout, grp_g, grp_p;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cla16_adder uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
                   .grp_g(grp_g), .grp_p(grp_p));

  // {cin, a, b}
  localparam logic [32:0] VEC [16] = '{
    {1'b0, 16'h0000, 16'h0000}, {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0001}, {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h1234, 16'h4321}, {1'b1, 16'hA5A5, 16'h5A5A},
    {1'b0, 16'h8000, 16'h8000}, {1'b1, 16'h7FFF, 16'h0000},
    {1'b0, 16'h0F0F, 16'h00F1}, {1'b1, 16'hDEAD, 16'hBEEF},
    {1'b0, 16'hCAFE, 16'h3502}, {1'b1, 16'h00FF, 16'hFF00},
    {1'b0, 16'h8421, 16'h1248}, {1'b1, 16'h3333, 16'hCCCC},
    {1'b0, 16'hFFF0, 16'h0010}, {1'b1, 16'h0001, 16'hFFFE}
  };

  task automatic chk(string req, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(logic [15:0] va, logic [15:0] vb, logic vc);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'b0, c};
  endfunction

  function automatic logic ref_g(logic [15:0] x, logic [15:0] y);
    logic [16:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[16];
  endfunction

  function automatic logic ref_p(logic [15:0] x, logic [15:0] y);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 16; i++) if (!(x[i] || y[i])) r = 1'b0;
    return r;
  endfunction

  task automatic full_check(string req);
    chk(req, {cout, sum}, ref_add(a, b, cin));
    chk("R7", {16'b0, grp_g}, {16'b0, ref_g(a, b)});
    chk("R2", {16'b0, grp_p}, {16'b0, ref_p(a, b)});
    chk("R8", {16'b0, cout}, {16'b0, ref_g(a, b) | (ref_p(a, b) & cin)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: zero operands give all-zero outputs (R1).
    chk("R1", {cout, sum}, 17'h0);
    chk("R7", {16'b0, grp_g}, 17'h0);
    chk("R2", {16'b0, grp_p}, 17'h0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][31:16], VEC[i][15:0], VEC[i][32]);
      full_check("R1");
    end

    apply(16'h0007, 16'h0001, 1'b0);
    chk("R3", {cout, sum}, 17'h00008);
    apply(16'h00FF, 16'h0001, 1'b0);
    chk("R4", {cout, sum}, 17'h00100);
    apply(16'h000F, 16'h0000, 1'b1);
    chk("R4", {cout, sum}, 17'h00010);
    apply(16'h0FFF, 16'h0001, 1'b0);
    chk("R5", {cout, sum}, 17'h01000);
    apply(16'h0F00, 16'h0000, 1'b0);
    apply(16'h0FFF, 16'h0000, 1'b1);
    chk("R5", {cout, sum}, 17'h01000);
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R6", {cout, sum}, 17'h10000);
    apply(16'hF0F0, 16'h0F0F, 1'b1);
    chk("R6", {cout, sum}, 17'h10000);
    chk("R2", {16'b0, grp_p}, 17'h1);
    apply(16'hFFFE, 16'h0000, 1'b1);
    chk("R2", {16'b0, grp_p}, 17'h0);
    chk("R1", {cout, sum}, 17'h0FFFF);
    apply(16'h8000, 16'h8000, 1'b0);
    chk("R7", {16'b0, grp_g}, 17'h1);
    chk("R8", {16'b0, cout}, 17'h1);

    // R9: toggling cin leaves the span pair unchanged.
    begin
      logic g0, p0;
      apply(16'h5555, 16'hAAAA, 1'b0);
      g0 = grp_g; p0 = grp_p;
      apply(16'h5555, 16'hAAAA, 1'b1);
      chk("R9", {15'b0, grp_g, grp_p}, {15'b0, g0, p0});
      chk("R9", {16'b0, cout}, 17'h1);
      apply(16'h1F00, 16'h2100, 1'b0);
      g0 = grp_g; p0 = grp_p;
      apply(16'h1F00, 16'h2100, 1'b1);
      chk("R9", {15'b0, grp_g, grp_p}, {15'b0, g0, p0});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule